// File: doc/BRIEF.md
# Center-Symmetric Carrier PWM Generator

This block drives one complementary switch pair from an up-down (triangular) carrier. The carrier counts up from its start value to the period and back down with ramps of equal length, so one carrier cycle lasts twice the period in clocks. A comparator turns the carrier and a compare value into a raw PWM level. A dead-time state machine then splits that level into a high-side and a low-side gate. The two gates never overlap, and each turn-on waits the same programmed gap after the opposite gate turns off.

Period, compare value and phase start are taken from shadow inputs. They are copied into the active registers together in one clock, only at a carrier valley, and only on every N-th valley. Between these loads the active values do not change, which keeps every carrier cycle symmetric while the frequency is changed at run time. A one-clock synchronisation pulse marks each new carrier cycle as a plain logic output. Several instances can be interleaved by giving each a different phase start.

The carrier FSM has the states CAR_INIT (first load after reset), CAR_UP and CAR_DN. Its transitions are INIT→UP/DN (load), UP→DN (peak reached), DN→UP (valley, with a load on the N-th valley) and DN→UP/DN (a load with a phase start). The dead-time FSM has the states DT_LO_ON, DT_GAP_HI, DT_HI_ON and DT_GAP_LO. Its transitions are LO_ON→GAP_HI (raw rises), GAP_HI→HI_ON (gap done), GAP_HI→GAP_LO (raw falls early, which suppresses the pulse), HI_ON→GAP_LO (raw falls), GAP_LO→LO_ON (gap done) and GAP_LO→GAP_HI (raw rises early).

Top module: `sym_pwm_gen`

## Requirements
- R1: The carrier counter runs up by one per clock until it reaches the active period P, then down by one per clock until it reaches the valley. From a zero start a full cycle therefore visits 0,1,…,P,…,1 and lasts 2P clocks, with no value above P.
- R2: The active period, compare value, phase start and start direction are all copied from the shadow inputs in the same clock, never separately.
- R3: A load occurs in the clock after reset release, and afterwards only at a valley. A valley is the step in which the counter, counting down, is at 1 or below. A load happens only when the internal valley count has reached N-1, where N is `hold_n` and a value of 0 acts as 1. The valley count returns to 0 on each load. A valley without a load restarts the counter at 0 counting up.
- R4: `sync_pulse` is high for exactly one clock, in the clock that follows each valley step. This is the first clock of the new carrier cycle.
- R5: The raw PWM level is 1 while counter < compare value. A compare value of 0 keeps the high side off, and a compare value ≥ P keeps the raw level at 1 for the whole cycle.
- R6: `gate_hi` and `gate_lo` are never both 1. A gate rises only after the opposite gate has been low for max(`dead_cyc`,1) whole clocks.
- R7: The same gap of max(`dead_cyc`,1) clocks with both gates low is inserted on the raw rising transition and on the raw falling transition.
- R8: If the raw level returns before the gap has elapsed, the pending gate does not turn on, and the other gate gets a fresh gap.
- R9: At a load, the start value is min(`shd_phase`,P). The start direction is down when `shd_phase_dn`=1, except that a start of 0 always counts up and a start of P always counts down.
- R10: While reset is asserted, both gates and `sync_pulse` are 0. After release the dead-time FSM starts in DT_GAP_LO, so `gate_lo` comes on only after the gap.
- R11: A shadow period of 0 is loaded as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shd_period | input | CW | Shadow carrier period P (half cycle in clocks) |
| shd_cmp | input | CW | Shadow compare value (modulation) |
| shd_phase | input | CW | Shadow phase start value |
| shd_phase_dn | input | 1 | Shadow start direction, 1 = down |
| hold_n | input | NW | Carrier cycles per load, N (0 acts as 1) |
| dead_cyc | input | DW | Dead time in clocks |
| gate_hi | output | 1 | High-side gate |
| gate_lo | output | 1 | Low-side gate |
| sync_pulse | output | 1 | One-clock carrier boundary pulse |

## Verification
The hardest situation to reach from the ports is a shadow change that lands between two loads when N is greater than 1. The outputs must keep the old period and compare value until the N-th valley. The bench therefore changes all shadow values in the middle of a hold window and compares every clock against a behavioural model that keeps its own valley count. Pulse suppression is reached with a compare value of 1, which gives a single-clock raw pulse, together with a dead time of 3. Phase starts are checked by measuring the spacing of the sync pulses, which shrinks when each load restarts the carrier at a non-zero start value.

// File: rtl/sym_pwm_pkg.sv
package sym_pwm_pkg;
    typedef enum logic [1:0] {CAR_INIT, CAR_UP, CAR_DN} car_st_t;
    typedef enum logic [1:0] {DT_LO_ON, DT_GAP_HI, DT_HI_ON, DT_GAP_LO} dt_st_t;
endpackage

// File: rtl/sym_car_cnt.sv
module sym_car_cnt
    import sym_pwm_pkg::*;
#(
    parameter int CW = 12,
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] shd_period,
    input  logic [CW-1:0] shd_cmp,
    input  logic [CW-1:0] shd_phase,
    input  logic          shd_phase_dn,
    input  logic [NW-1:0] hold_n,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] act_per,
    output logic [CW-1:0] act_cmp,
    output logic          sync_pulse
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    car_st_t       st, st_n;
    logic [CW-1:0] cnt_n, ld_per, ld_ph;
    logic [NW-1:0] hc, hc_n, n_m1;
    car_st_t       ld_st;
    logic          valley, peak_hit, load;

    always_comb begin
        ld_per   = (shd_period == '0) ? ONE : shd_period;
        ld_ph    = (shd_phase > ld_per) ? ld_per : shd_phase;
        if (ld_ph == '0)          ld_st = CAR_UP;
        else if (ld_ph == ld_per) ld_st = CAR_DN;
        else                      ld_st = shd_phase_dn ? CAR_DN : CAR_UP;
        n_m1     = (hold_n == '0) ? '0 : hold_n - 1'b1;
        valley   = (st == CAR_DN) && (cnt <= ONE);
        peak_hit = (st == CAR_UP) && ({1'b0, cnt} + 1'b1 >= {1'b0, act_per});
        load     = (st == CAR_INIT) || (valley && (hc >= n_m1));
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        hc_n  = hc;
        unique case (st)
            CAR_INIT: ;
            CAR_UP: begin
                if (peak_hit) begin
                    cnt_n = act_per;
                    st_n  = CAR_DN;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            CAR_DN: begin
                if (cnt <= ONE) begin
                    cnt_n = '0;
                    st_n  = CAR_UP;
                    hc_n  = hc + 1'b1;
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            default: st_n = CAR_INIT;
        endcase
        if (load) begin
            cnt_n = ld_ph;
            st_n  = ld_st;
            hc_n  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= CAR_INIT;
            cnt <= '0;
            hc  <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            hc  <= hc_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_per    <= ONE;
            act_cmp    <= '0;
            sync_pulse <= 1'b0;
        end else begin
            sync_pulse <= valley;
            if (load) begin
                act_per <= ld_per;
                act_cmp <= shd_cmp;
            end
        end
    end

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= act_per);
    // R1
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CAR_DN && cnt > ONE) |=> (cnt == $past(cnt) - 1'b1));
    // R2
    load_at_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_per != $past(act_per) || act_cmp != $past(act_cmp))
            |-> (sync_pulse || $past(st) == CAR_INIT));
    // R4
    sync_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> !sync_pulse);
endmodule

// File: rtl/sym_dt_fsm.sv
module sym_dt_fsm
    import sym_pwm_pkg::*;
#(
    parameter int DW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwm_raw,
    input  logic [DW-1:0] dead_cyc,
    output logic          gate_hi,
    output logic          gate_lo
);
    dt_st_t        st, st_n;
    logic [DW-1:0] dtc, dtc_n;
    logic          gap_done;

    always_comb begin
        gap_done = ({1'b0, dtc} + 1'b1) >= {1'b0, dead_cyc};
        st_n  = st;
        dtc_n = dtc + 1'b1;
        unique case (st)
            DT_LO_ON:  if (pwm_raw) begin st_n = DT_GAP_HI; dtc_n = '0; end
            DT_HI_ON:  if (!pwm_raw) begin st_n = DT_GAP_LO; dtc_n = '0; end
            DT_GAP_HI: begin
                if (!pwm_raw)     begin st_n = DT_GAP_LO; dtc_n = '0; end
                else if (gap_done) st_n = DT_HI_ON;
            end
            DT_GAP_LO: begin
                if (pwm_raw)      begin st_n = DT_GAP_HI; dtc_n = '0; end
                else if (gap_done) st_n = DT_LO_ON;
            end
            default: begin st_n = DT_GAP_LO; dtc_n = '0; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= DT_GAP_LO;
            dtc <= '0;
        end else begin
            st  <= st_n;
            dtc <= dtc_n;
        end
    end

    always_comb begin
        gate_hi = (st == DT_HI_ON);
        gate_lo = (st == DT_LO_ON);
    end

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));
    // R6
    hi_after_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> !$past(gate_lo));
    // R7
    lo_after_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_lo) |-> !$past(gate_hi));
    // R8
    hi_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> $past(pwm_raw));
endmodule

// File: rtl/sym_pwm_gen.sv
module sym_pwm_gen
    import sym_pwm_pkg::*;
#(
    parameter int CW = 12,
    parameter int NW = 4,
    parameter int DW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] shd_period,
    input  logic [CW-1:0] shd_cmp,
    input  logic [CW-1:0] shd_phase,
    input  logic          shd_phase_dn,
    input  logic [NW-1:0] hold_n,
    input  logic [DW-1:0] dead_cyc,
    output logic          gate_hi,
    output logic          gate_lo,
    output logic          sync_pulse
);
    logic [CW-1:0] cnt, act_per, act_cmp;
    logic          pwm_raw;

    sym_car_cnt #(.CW(CW), .NW(NW)) u_car (
        .clk(clk), .rst_n(rst_n),
        .shd_period(shd_period), .shd_cmp(shd_cmp),
        .shd_phase(shd_phase), .shd_phase_dn(shd_phase_dn),
        .hold_n(hold_n), .cnt(cnt), .act_per(act_per),
        .act_cmp(act_cmp), .sync_pulse(sync_pulse)
    );

    always_comb pwm_raw = (act_cmp >= act_per) || (cnt < act_cmp);

    sym_dt_fsm #(.DW(DW)) u_dt (
        .clk(clk), .rst_n(rst_n), .pwm_raw(pwm_raw),
        .dead_cyc(dead_cyc), .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    // R5
    zero_cmp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cmp == '0 && $past(act_cmp) == '0) |-> !$rose(gate_hi));
endmodule

// File: tb/sim_sym_pwm_gen.sv
`timescale 1ns/1ps
module sim_sym_pwm_gen;
    localparam int CW = 12, NW = 4, DW = 6;
    logic clk = 0, rst_n = 0;
    logic [CW-1:0] per = 10, cmpv = 4, ph = 0;
    logic phdn = 0;
    logic [NW-1:0] hold = 1;
    logic [DW-1:0] dead = 2;
    logic gate_hi, gate_lo, sync_pulse;
    int n_cmp = 0, n_bad = 0, cyc = 0;
    string tag = "R10";

    always #4 clk = ~clk;

    sym_pwm_gen #(.CW(CW), .NW(NW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .shd_period(per), .shd_cmp(cmpv),
        .shd_phase(ph), .shd_phase_dn(phdn), .hold_n(hold), .dead_cyc(dead),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .sync_pulse(sync_pulse)
    );

    // behavioural reference
    int m_cnt, m_per, m_cmp, m_hc, m_dst, m_dtc;
    bit m_up, m_init, m_sync;

    task automatic chk(input bit ok, input string t, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", t, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_per = 1; m_cmp = 0; m_hc = 0; m_up = 1; m_init = 1;
            m_sync = 0; m_dst = 3; m_dtc = 0;
        end else begin
            automatic bit raw = (m_cmp >= m_per) || (m_cnt < m_cmp);
            automatic int dmin = (dead == 0) ? 1 : int'(dead);
            automatic int nn = (hold == 0) ? 1 : int'(hold);
            automatic bit ld = 0;
            // dead time
            case (m_dst)
                0: if (raw) begin m_dst = 1; m_dtc = 0; end
                2: if (!raw) begin m_dst = 3; m_dtc = 0; end
                1: if (!raw) begin m_dst = 3; m_dtc = 0; end
                   else if (m_dtc + 1 >= dmin) m_dst = 2; else m_dtc++;
                default: if (raw) begin m_dst = 1; m_dtc = 0; end
                   else if (m_dtc + 1 >= dmin) m_dst = 0; else m_dtc++;
            endcase
            // carrier
            m_sync = 0;
            if (m_init) ld = 1;
            else if (m_up) begin
                if (m_cnt + 1 >= m_per) begin m_cnt = m_per; m_up = 0; end
                else m_cnt++;
            end else if (m_cnt <= 1) begin
                m_sync = 1;
                if (m_hc >= nn - 1) ld = 1;
                else begin m_hc++; m_cnt = 0; m_up = 1; end
            end else m_cnt--;
            if (ld) begin
                m_per = (per == 0) ? 1 : int'(per);
                m_cmp = cmpv;
                m_cnt = (int'(ph) > m_per) ? m_per : int'(ph);
                m_up = (m_cnt == 0) ? 1'b1 : (m_cnt == m_per) ? 1'b0 : !phdn;
                m_hc = 0; m_init = 0;
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        chk(gate_hi == (m_dst == 2), {tag, " gate_hi"}, gate_hi, m_dst == 2);
        chk(gate_lo == (m_dst == 0), {tag, " gate_lo"}, gate_lo, m_dst == 0);
        chk(sync_pulse == m_sync, {tag, " sync_pulse"}, sync_pulse, m_sync);
        if (gate_hi && gate_lo) chk(0, "R6 overlap", 1, 0);
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sync_gap(output int g);
        while (!sync_pulse) @(negedge clk);
        g = 0;
        do begin @(negedge clk); g++; end while (!sync_pulse);
    endtask

    initial begin
        int g, cnt1;
        bit seen;
        wcyc(3);
        chk(!gate_hi && !gate_lo && !sync_pulse, "R10 reset outputs", gate_hi | gate_lo | sync_pulse, 0);
        rst_n = 1;
        wcyc(1);
        chk(!gate_lo, "R10 lo waits gap", gate_lo, 0);
        // basic
        tag = "R5"; wcyc(60);
        sync_gap(g); chk(g == 20, "R1 cycle length", g, 20);
        while (!sync_pulse) @(negedge clk);
        @(negedge clk); chk(!sync_pulse, "R4 one clock", sync_pulse, 0);
        // hold window with mid-window change
        tag = "R3"; hold = 3; wcyc(70);
        while (!sync_pulse) @(negedge clk);
        wcyc(7); per = 6; cmpv = 5; tag = "R2"; wcyc(130);
        sync_gap(g); chk(g == 12, "R2 new period", g, 12);
        hold = 1; tag = "R3"; wcyc(40);
        // compare 0
        tag = "R5"; per = 8; cmpv = 0; wcyc(40);
        seen = 0; for (int i = 0; i < 32; i++) begin @(negedge clk); seen |= gate_hi; end
        chk(!seen, "R5 cmp zero off", seen, 0);
        // compare >= period
        cmpv = 20; wcyc(40);
        cnt1 = 0; for (int i = 0; i < 32; i++) begin @(negedge clk); cnt1 += gate_hi; end
        chk(cnt1 == 32, "R5 full on", cnt1, 32);
        // suppression
        tag = "R8"; cmpv = 1; dead = 3; wcyc(40);
        seen = 0; for (int i = 0; i < 48; i++) begin @(negedge clk); seen |= gate_hi; end
        chk(!seen, "R8 short pulse suppressed", seen, 0);
        // symmetric dead time
        tag = "R7"; per = 16; cmpv = 8; dead = 4; wcyc(80);
        while (!gate_lo) @(negedge clk);
        while (gate_lo) @(negedge clk);
        g = 0; while (!gate_hi) begin @(negedge clk); g++; end
        chk(g == 4, "R7 gap before hi", g, 4);
        while (gate_hi) @(negedge clk);
        g = 0; while (!gate_lo) begin @(negedge clk); g++; end
        chk(g == 4, "R6 gap before lo", g, 4);
        // phase starts
        tag = "R9"; per = 10; cmpv = 3; dead = 1; ph = 5; phdn = 1; wcyc(60);
        sync_gap(g); chk(g == 5, "R9 down start", g, 5);
        phdn = 0; wcyc(60);
        sync_gap(g); chk(g == 15, "R9 up start", g, 15);
        ph = 30; wcyc(60);
        sync_gap(g); chk(g == 10, "R9 clamp to peak", g, 10);
        ph = 0; phdn = 1; wcyc(60);
        sync_gap(g); chk(g == 20, "R9 zero start up", g, 20);
        // period zero
        tag = "R11"; per = 0; cmpv = 0; wcyc(60);
        sync_gap(g); chk(g == 2, "R11 period zero", g, 2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule